// File: doc/BRIEF.md
# Reconfiguration Prefetch Arbiter

This block sits between a processor's decision logic and a partial-reconfiguration loader. At each program decision point, signalled by a one-cycle strobe, it receives a short queue of candidate hardware module IDs ranked by priority. It also sees a bitmap of the modules that are already resident in the reconfigurable fabric and the loader's status, which is either the ID of the module being written or a reserved "none" code. From these it decides whether to start or resume a load, and whether the load preempts the transfer in progress. The decision is registered and appears one cycle after the strobe. When a load is issued, the block also presents the set of resident modules whose placement overlaps the chosen one, so that their resident bits can be dropped.

The block also decides what happens when a hardware module is reached in program flow. A resident module runs in hardware. A module that is still being written is waited for only when its remaining reconfiguration time plus its hardware latency beats its software latency. In every other case the software version runs. Remaining time comes from per-module progress counters. These counters advance on every cycle the loader reports that module as busy and are cleared once the module is resident, so a preempted load can later be resumed instead of restarted.

Module IDs are 4 bits wide. Code 4'hF means "none", so modules 0 to 14 exist. Queue entry 0 has the highest priority.

Top module: `rpa_prefetch_arbiter`

## Requirements
- R1: One cycle after a strobe, if entry 0 is valid, its module is not resident and the loader is idle (ldr_id = 4'hF), the block raises ld_req with ld_id set to that module and ld_preempt low.
- R2: If entry 0 is resident and the loader is idle, the request targets the lowest-indexed valid entry whose module is not resident, skipping invalid entries. If entry 0 is resident and the loader is busy, no request is made.
- R3: If the loader is busy with a module other than the non-resident entry-0 module, the block requests entry 0 with ld_preempt high. If the loader is already busy with the entry-0 module, no request is made.
- R4: Without a strobe, with entry 0 invalid, or with every valid entry resident, ld_req stays low and ld_id reads 0.
- R5: ld_resume is high with a request exactly when the chosen module has accumulated progress: one or more cycles reported busy by the loader since the module was last seen resident.
- R6: With a request, clr_mask equals the conflict row of the chosen module (bit j set when module j overlaps it; the default map makes modules 0 and 1 overlap). Without a request, clr_mask is 0.
- R7: One cycle after reach_vld, exec_vld is high. If the reached module is resident, exec_mode is 2'd1 (hardware).
- R8: A reached module that the loader reports busy gets exec_mode 2'd2 (wait) when (REC_CYC − progress) + hw latency < sw latency, and 2'd0 (software) otherwise. A non-resident module that is not being loaded gets 2'd0.
- R9: While reset is asserted, and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_vld | input | 1 | Decision-point strobe |
| q_vld | input | DEPTH | Valid bit per queue entry |
| q_ids | input | DEPTH*IDW | Queue module IDs, entry i at bits [i*IDW +: IDW], entry 0 highest priority |
| loaded_map | input | 15 | Resident bit per module |
| ldr_id | input | IDW | Module being reconfigured, 4'hF when idle |
| reach_vld | input | 1 | A hardware module is reached |
| reach_id | input | IDW | ID of the reached module |
| reach_hw_lat | input | LATW | Hardware latency of the reached module |
| reach_sw_lat | input | LATW | Software latency of the reached module |
| ld_req | output | 1 | Start or resume a load |
| ld_id | output | IDW | Module to load |
| ld_resume | output | 1 | The load continues an interrupted transfer |
| ld_preempt | output | 1 | Abort the ongoing transfer first |
| clr_mask | output | 15 | Modules whose resident bit must be dropped |
| exec_vld | output | 1 | Execution decision valid |
| exec_mode | output | 2 | 0 software, 1 hardware, 2 wait |

## Verification
The checker enforces the following on every cycle:
- a request only ever follows a strobe and targets a module that was not resident;
- preemption only happens when the loader was busy;
- a non-preempting request only happens when the loader was idle;
- a hardware verdict requires a resident module;
- a wait verdict requires that the loader was writing exactly that module.

Other behaviours need the bench's scenarios: which queue entry wins, the exact threshold of the wait-versus-software comparison after a known number of busy cycles, the resume flag being set and then cleared, and the conflict row that is presented.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
   typedef enum logic [1:0] {
      EX_SW   = 2'd0,
      EX_HW   = 2'd1,
      EX_WAIT = 2'd2
   } exec_mode_e;
endpackage

// File: rtl/rpa_prog_track.sv
module rpa_prog_track #(
   parameter int IDW     = 4,
   parameter int NMOD    = 15,
   parameter int REC_CYC = 40,
   parameter int PW      = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDW-1:0]      ldr_id,
   input  logic [NMOD-1:0]     loaded_map,
   output logic [NMOD*PW-1:0]  prog_flat
);
   localparam logic [PW-1:0] LIMIT = PW'(REC_CYC);

   for (genvar m = 0; m < NMOD; m++) begin : g_ctr
      logic [PW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (loaded_map[m]) begin
            cnt <= '0;
         end else if (ldr_id == IDW'(m) && cnt < LIMIT) begin
            cnt <= cnt + 1'b1;
         end
      end
      assign prog_flat[m*PW +: PW] = cnt;
   end
endmodule

// File: rtl/rpa_prefetch_sel.sv
module rpa_prefetch_sel #(
   parameter int IDW   = 4,
   parameter int DEPTH = 4,
   parameter int NMOD  = 15
) (
   input  logic [DEPTH-1:0]     q_vld,
   input  logic [DEPTH*IDW-1:0] q_ids,
   input  logic [NMOD-1:0]      loaded_map,
   input  logic [IDW-1:0]       ldr_id,
   output logic                 go,
   output logic                 preempt,
   output logic [IDW-1:0]       sel_id
);
   localparam logic [IDW-1:0] NONE = {IDW{1'b1}};

   logic [NMOD:0]          res_ext;
   logic [IDW-1:0]         ent [DEPTH];
   logic [DEPTH-1:1]       cand;
   logic                   head_ok, head_res, idle, head_busy;

   assign res_ext = {1'b1, loaded_map};

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign ent[i] = q_ids[i*IDW +: IDW];
   end
   for (genvar i = 1; i < DEPTH; i++) begin : g_cand
      assign cand[i] = q_vld[i] && (ent[i] != NONE) && !res_ext[ent[i]];
   end

   assign head_ok   = q_vld[0] && (ent[0] != NONE);
   assign head_res  = res_ext[ent[0]];
   assign idle      = (ldr_id == NONE);
   assign head_busy = (ldr_id == ent[0]);

   always_comb begin
      logic found;
      found   = 1'b0;
      go      = 1'b0;
      preempt = 1'b0;
      sel_id  = '0;
      if (head_ok) begin
         if (!head_res) begin
            if (idle) begin
               go     = 1'b1;
               sel_id = ent[0];
            end else if (!head_busy) begin
               go      = 1'b1;
               preempt = 1'b1;
               sel_id  = ent[0];
            end
         end else if (idle) begin
            for (int i = 1; i < DEPTH; i++) begin
               if (!found && cand[i]) begin
                  found  = 1'b1;
                  go     = 1'b1;
                  sel_id = ent[i];
               end
            end
         end
      end
   end
endmodule

// File: rtl/rpa_reach_eval.sv
module rpa_reach_eval
   import rpa_pkg::*;
#(
   parameter int IDW     = 4,
   parameter int NMOD    = 15,
   parameter int LATW    = 8,
   parameter int REC_CYC = 40,
   parameter int PW      = 6
) (
   input  logic [IDW-1:0]     reach_id,
   input  logic [LATW-1:0]    hw_lat,
   input  logic [LATW-1:0]    sw_lat,
   input  logic [NMOD-1:0]    loaded_map,
   input  logic [IDW-1:0]     ldr_id,
   input  logic [NMOD*PW-1:0] prog_flat,
   output exec_mode_e         mode
);
   localparam int SUMW = ((LATW > PW) ? LATW : PW) + 1;

   logic [NMOD:0]          res_ext;
   logic [(NMOD+1)*PW-1:0] prog_ext;
   logic [PW-1:0]          prog_sel, rem;
   logic [SUMW-1:0]        total;

   assign res_ext  = {1'b1, loaded_map};
   assign prog_ext = {{PW{1'b0}}, prog_flat};
   assign prog_sel = prog_ext[reach_id*PW +: PW];
   assign rem      = PW'(REC_CYC) - prog_sel;
   assign total    = SUMW'(rem) + SUMW'(hw_lat);

   always_comb begin
      if (reach_id == {IDW{1'b1}}) begin
         mode = EX_SW;
      end else if (res_ext[reach_id]) begin
         mode = EX_HW;
      end else if (ldr_id == reach_id && total < SUMW'(sw_lat)) begin
         mode = EX_WAIT;
      end else begin
         mode = EX_SW;
      end
   end
endmodule

// File: rtl/rpa_prefetch_arbiter.sv
module rpa_prefetch_arbiter
   import rpa_pkg::*;
#(
   parameter int IDW     = 4,
   parameter int DEPTH   = 4,
   parameter int LATW    = 8,
   parameter int REC_CYC = 40,
   parameter logic [((1<<IDW)-1)*((1<<IDW)-1)-1:0] CONF_MAP = 'h8002
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dp_vld,
   input  logic [DEPTH-1:0]      q_vld,
   input  logic [DEPTH*IDW-1:0]  q_ids,
   input  logic [(1<<IDW)-2:0]   loaded_map,
   input  logic [IDW-1:0]        ldr_id,
   input  logic                  reach_vld,
   input  logic [IDW-1:0]        reach_id,
   input  logic [LATW-1:0]       reach_hw_lat,
   input  logic [LATW-1:0]       reach_sw_lat,
   output logic                  ld_req,
   output logic [IDW-1:0]        ld_id,
   output logic                  ld_resume,
   output logic                  ld_preempt,
   output logic [(1<<IDW)-2:0]   clr_mask,
   output logic                  exec_vld,
   output logic [1:0]            exec_mode
);
   localparam int NMOD = (1 << IDW) - 1;
   localparam int PW   = $clog2(REC_CYC + 1);

   if (IDW < 2 || IDW > 6) begin : g_bad_idw
      $error("rpa_prefetch_arbiter: IDW out of range");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("rpa_prefetch_arbiter: DEPTH must be at least 2");
   end
   if (REC_CYC < 1) begin : g_bad_rec
      $error("rpa_prefetch_arbiter: REC_CYC must be positive");
   end

   logic [NMOD*PW-1:0]       prog_flat;
   logic [(NMOD+1)*PW-1:0]   prog_ext;
   logic [(NMOD+1)*NMOD-1:0] conf_ext;
   logic                     go, pre;
   logic [IDW-1:0]           sel_id;
   exec_mode_e               mode;
   logic                     fire;

   rpa_prog_track #(.IDW(IDW), .NMOD(NMOD), .REC_CYC(REC_CYC), .PW(PW)) u_prog (
      .clk(clk), .rst_n(rst_n), .ldr_id(ldr_id),
      .loaded_map(loaded_map), .prog_flat(prog_flat)
   );

   rpa_prefetch_sel #(.IDW(IDW), .DEPTH(DEPTH), .NMOD(NMOD)) u_sel (
      .q_vld(q_vld), .q_ids(q_ids), .loaded_map(loaded_map), .ldr_id(ldr_id),
      .go(go), .preempt(pre), .sel_id(sel_id)
   );

   rpa_reach_eval #(.IDW(IDW), .NMOD(NMOD), .LATW(LATW), .REC_CYC(REC_CYC), .PW(PW)) u_eval (
      .reach_id(reach_id), .hw_lat(reach_hw_lat), .sw_lat(reach_sw_lat),
      .loaded_map(loaded_map), .ldr_id(ldr_id), .prog_flat(prog_flat), .mode(mode)
   );

   assign prog_ext = {{PW{1'b0}}, prog_flat};
   assign conf_ext = {{NMOD{1'b0}}, CONF_MAP};
   assign fire     = dp_vld && go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_req     <= 1'b0;
         ld_id      <= '0;
         ld_resume  <= 1'b0;
         ld_preempt <= 1'b0;
         clr_mask   <= '0;
         exec_vld   <= 1'b0;
         exec_mode  <= 2'd0;
      end else begin
         ld_req     <= fire;
         ld_id      <= fire ? sel_id : '0;
         ld_preempt <= fire && pre;
         ld_resume  <= fire && (prog_ext[sel_id*PW +: PW] != '0);
         clr_mask   <= fire ? conf_ext[sel_id*NMOD +: NMOD] : '0;
         exec_vld   <= reach_vld;
         exec_mode  <= reach_vld ? mode : EX_SW;
      end
   end
endmodule

// File: rtl/rpa_checker.sv
module rpa_checker #(
   parameter int IDW = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 dp_vld,
   input logic [IDW-1:0]       ldr_id,
   input logic [(1<<IDW)-2:0]  loaded_map,
   input logic [IDW-1:0]       reach_id,
   input logic                 ld_req,
   input logic [IDW-1:0]       ld_id,
   input logic                 ld_preempt,
   input logic                 exec_vld,
   input logic [1:0]           exec_mode
);
   localparam int NMOD = (1 << IDW) - 1;
   localparam logic [IDW-1:0] NONE = {IDW{1'b1}};

   logic [NMOD:0]   res_q;
   logic [IDW-1:0]  ldr_q, reach_q;
   logic            dp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q   <= '1;
         ldr_q   <= NONE;
         reach_q <= NONE;
         dp_q    <= 1'b0;
      end else begin
         res_q   <= {1'b1, loaded_map};
         ldr_q   <= ldr_id;
         reach_q <= reach_id;
         dp_q    <= dp_vld;
      end
   end

   a_r4_req_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |-> dp_q);
   a_r1_target_not_resident: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |-> !res_q[ld_id]);
   a_r3_preempt_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ld_preempt |-> (ld_req && ldr_q != NONE && ldr_q != ld_id));
   a_r2_plain_load_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && !ld_preempt) |-> (ldr_q == NONE));
   a_r7_hw_needs_resident: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_vld && exec_mode == 2'd1) |-> res_q[reach_q]);
   a_r8_wait_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_vld && exec_mode == 2'd2) |-> (ldr_q == reach_q && !res_q[reach_q]));
   a_r9_quiet_exec: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_vld |-> (exec_mode == 2'd0));
endmodule

bind rpa_prefetch_arbiter rpa_checker #(.IDW(IDW)) u_chk (
   .clk(clk), .rst_n(rst_n), .dp_vld(dp_vld), .ldr_id(ldr_id),
   .loaded_map(loaded_map), .reach_id(reach_id), .ld_req(ld_req),
   .ld_id(ld_id), .ld_preempt(ld_preempt), .exec_vld(exec_vld),
   .exec_mode(exec_mode)
);

// File: tb/tb_rpa_prefetch_arbiter.sv
module tb_rpa_prefetch_arbiter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        dp_vld;
   logic [3:0]  q_vld;
   logic [15:0] q_ids;
   logic [14:0] loaded_map;
   logic [3:0]  ldr_id;
   logic        reach_vld;
   logic [3:0]  reach_id;
   logic [7:0]  reach_hw_lat, reach_sw_lat;
   logic        ld_req, ld_resume, ld_preempt, exec_vld;
   logic [3:0]  ld_id;
   logic [14:0] clr_mask;
   logic [1:0]  exec_mode;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   rpa_prefetch_arbiter dut (
      .clk(clk), .rst_n(rst_n), .dp_vld(dp_vld), .q_vld(q_vld), .q_ids(q_ids),
      .loaded_map(loaded_map), .ldr_id(ldr_id), .reach_vld(reach_vld),
      .reach_id(reach_id), .reach_hw_lat(reach_hw_lat), .reach_sw_lat(reach_sw_lat),
      .ld_req(ld_req), .ld_id(ld_id), .ld_resume(ld_resume), .ld_preempt(ld_preempt),
      .clr_mask(clr_mask), .exec_vld(exec_vld), .exec_mode(exec_mode)
   );

   // {q_vld, q_ids(entry3..entry0), loaded_map, ldr_id, exp_req, exp_id, exp_pre}
   localparam logic [44:0] VEC [10] = '{
      {4'b0011, 16'h0032, 15'h0000, 4'hF, 1'b1, 4'h2, 1'b0},  // R1 idle, head 2 loads
      {4'b0011, 16'h0032, 15'h0004, 4'hF, 1'b1, 4'h3, 1'b0},  // R2 head resident, next loads
      {4'b0011, 16'h0032, 15'h0004, 4'h7, 1'b0, 4'h0, 1'b0},  // R2 busy, no fallback
      {4'b0011, 16'h0032, 15'h0000, 4'h3, 1'b1, 4'h2, 1'b1},  // R3 preempt lower entry
      {4'b0011, 16'h0032, 15'h0000, 4'h2, 1'b0, 4'h0, 1'b0},  // R3 head already loading
      {4'b0011, 16'h0032, 15'h0000, 4'h7, 1'b1, 4'h2, 1'b1},  // R3 preempt module not queued
      {4'b0011, 16'h0032, 15'h000C, 4'hF, 1'b0, 4'h0, 1'b0},  // R4 all resident
      {4'b0000, 16'h0032, 15'h0000, 4'hF, 1'b0, 4'h0, 1'b0},  // R4 empty queue
      {4'b0101, 16'h0932, 15'h0004, 4'hF, 1'b1, 4'h9, 1'b0},  // R2 skip invalid entry
      {4'b1111, 16'h8632, 15'h004C, 4'hF, 1'b1, 4'h8, 1'b0}   // R2 deepest entry
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      dp_vld = 0; q_vld = '0; q_ids = '0; loaded_map = '0; ldr_id = 4'hF;
      reach_vld = 0; reach_id = 4'hF; reach_hw_lat = '0; reach_sw_lat = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_inputs();
      rst_n = 0;
      tick(); tick();
      rst_n = 1;
   endtask

   task automatic decide(input logic [3:0] head);
      dp_vld = 1; q_vld = 4'b0001; q_ids = {12'h0, head};
      tick();
      dp_vld = 0;
   endtask

   initial begin
      rst_n = 0;
      idle_inputs();
      do_reset();
      // R9: reset state
      chk("R9 ld_req", ld_req, 0);
      chk("R9 ld_id", ld_id, 0);
      chk("R9 exec_vld", exec_vld, 0);
      chk("R9 clr_mask", clr_mask, 0);

      for (int i = 0; i < 10; i++) begin
         q_vld = VEC[i][44:41]; q_ids = VEC[i][40:25]; loaded_map = VEC[i][24:10];
         ldr_id = VEC[i][9:6]; dp_vld = 1;
         tick();
         chk($sformatf("R1 R2 R3 R4 vec%0d req", i), ld_req, VEC[i][5]);
         chk($sformatf("R1 R2 R3 R4 vec%0d id", i), ld_id, VEC[i][4:1]);
         chk($sformatf("R3 vec%0d preempt", i), ld_preempt, VEC[i][0]);
      end

      // R4: no strobe, no request
      do_reset();
      q_vld = 4'b0011; q_ids = 16'h0032; dp_vld = 0;
      tick();
      chk("R4 no strobe", ld_req, 0);

      // R6: conflict rows
      decide(4'h0);
      chk("R6 clr for 0", clr_mask, 15'h0002);
      decide(4'h1);
      chk("R6 clr for 1", clr_mask, 15'h0001);
      decide(4'h2);
      chk("R6 clr for 2", clr_mask, 15'h0000);
      tick();
      chk("R6 clr idle", clr_mask, 15'h0000);

      // R5: resume flag
      do_reset();
      ldr_id = 4'h5;
      for (int k = 0; k < 30; k++) tick();
      ldr_id = 4'hF;
      decide(4'h5);
      chk("R5 resume after preempt", ld_resume, 1);
      chk("R5 resume id", ld_id, 4'h5);
      decide(4'h6);
      chk("R5 fresh load", ld_resume, 0);
      loaded_map = 15'h0020;
      tick();
      loaded_map = '0;
      decide(4'h5);
      chk("R5 progress cleared", ld_resume, 0);

      // R7/R8: reach decisions, progress 30 then 31
      do_reset();
      ldr_id = 4'h5;
      for (int k = 0; k < 30; k++) tick();
      reach_vld = 1; reach_id = 4'h5; reach_hw_lat = 8'd5; reach_sw_lat = 8'd20;
      tick();
      chk("R8 wait chosen", exec_mode, 2'd2);
      chk("R7 exec_vld", exec_vld, 1);
      reach_sw_lat = 8'd14;
      tick();
      chk("R8 equal means software", exec_mode, 2'd0);
      loaded_map = 15'h0020;
      tick();
      chk("R7 resident runs hw", exec_mode, 2'd1);
      loaded_map = '0; ldr_id = 4'hF; reach_id = 4'h6;
      reach_hw_lat = 8'd1; reach_sw_lat = 8'd200;
      tick();
      chk("R8 not loading means software", exec_mode, 2'd0);
      reach_vld = 0;
      tick();
      chk("R7 exec_vld drops", exec_vld, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule